// File: doc/BRIEF.md
# Audio FSK Modulator with NRZI Coding and Zero-Bit Insertion

This block turns a byte stream into 8-bit unsigned samples of a two-tone audio FSK signal, with 1200 Hz as the mark tone and 2200 Hz as the space tone at 1200 bit/s. A 9-bit phase accumulator walks one sine period of 512 steps. The sine is read from a 128-entry quarter-wave table and mirrored to give the other three quarters. Data bits are NRZI coded as tone changes. Zero bits are inserted after runs of ones, and each inserted zero is also a tone change.

A transmission opens with a run of flag bytes and closes with a run of flag bytes once no more input is waiting. Unescaped flag (0x7E) and abort (0x7F) bytes are sent without zero insertion. The escape byte 0x1B is never sent; it makes the next byte go out literally with zero insertion on. Bytes arrive on a valid/ready port that holds one byte. The surrounding logic pulses `sample_req` once per DAC sample period and takes `sample_out`.

Top module: `afsk_modulator`

## Requirements
- R1: After reset, and at any time the block is idle, `busy` is 0, `sample_out` is 0 and `in_ready` is 1. A `sample_req` while idle leaves `sample_out` at 0.
- R2: Quarter entry i (0..127) is 128 + round(127·sin(π(2i+1)/512)). For phase p, let i = p mod 256. If i ≥ 128 the entry read is 255−i. For p ≥ 256 the output is 255 minus the entry.
- R3: A phase step is round(512·f/SAMPLE_RATE): 64 for mark and 117 for space at 9600 samples/s. Each transmission starts at phase 0 on the mark tone. Each request adds the step of the tone then in force, and outputs the sine of the new phase.
- R4: A bit lasts SAMPLE_RATE/1200 requests (8 by default). The tone is chosen on the first request of each bit period. Bytes go out LSB first.
- R5: A data 1 keeps the tone and adds one to the ones count. A data 0 changes the tone and clears the count.
- R6: While zero insertion is on and the ones count is 5, the bit period carries an inserted 0 (tone change, count cleared) and no data bit is used.
- R7: Unescaped 0x7E and 0x7F are sent with zero insertion off. The ones count is cleared when the next byte starts, if the byte before it was sent with insertion off.
- R8: 0x1B is not transmitted. The byte after it is sent literally with zero insertion on, even if it is 0x7E or 0x7F.
- R9: Every transmission begins with round(PREAMBLE_MS·1200/8000) flag bytes (3 by default).
- R10: When a byte is due and none is waiting, flag bytes are sent until round(TRAILER_MS·1200/8000) of them (2 by default) have gone out since the last byte was accepted. The next request then ends the transmission: `sample_out` becomes 0 and `busy` becomes 0.
- R11: If a byte is due after the preamble, an escape is pending and no byte follows it, that request ends the transmission at once, with no trailer.
- R12: `in_ready` is 1 exactly when the one-byte holding stage is empty. A non-escape byte accepted while idle makes `in_ready` 0 one edge later, and `busy` rises on the edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 8 | Byte offered for transmission |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Holding stage can take a byte |
| sample_req | input | 1 | One-cycle request for the next sample |
| sample_out | output | 8 | Current unsigned sample |
| busy | output | 1 | A transmission is in progress |

## Verification
`sample_out` and `busy` change on the clock edge that samples a request. The bench therefore reads them at the falling edge right after that edge and compares them with a per-request reference model. `in_ready` falls one edge after an accepted byte, and `busy` rises one edge after that. The bench checks each of these at the falling edge that follows the edge in question. Requests are spaced four cycles apart, so the holding stage is always refilled before the next byte is due, and the model can treat the input as a plain queue.

// File: rtl/afskm_pkg.sv
package afskm_pkg;

    localparam int PHASE_W     = 9;
    localparam int PHASE_STEPS = 1 << PHASE_W;
    localparam int QTR_LEN     = PHASE_STEPS / 4;
    localparam int QTR_W       = PHASE_W - 2;
    localparam int SAMPLE_W    = 8;
    localparam int BAUD_HZ     = 1200;
    localparam int MARK_HZ     = 1200;
    localparam int SPACE_HZ    = 2200;
    localparam int STUFF_RUN   = 5;
    localparam int BYTE_BITS   = 8;

    localparam logic [7:0] FLAG_BYTE  = 8'h7E;
    localparam logic [7:0] ABORT_BYTE = 8'h7F;
    localparam logic [7:0] ESC_BYTE   = 8'h1B;

    typedef enum logic {
        TONE_MARK  = 1'b0,
        TONE_SPACE = 1'b1
    } tone_e;

    typedef struct packed {
        logic [7:0] value;
        logic       literal;
    } held_byte_t;

    // rounded phase step for a tone at a given sample rate
    function automatic int tone_step(int freq_hz, int rate_hz);
        return (PHASE_STEPS * freq_hz + rate_hz / 2) / rate_hz;
    endfunction

    // rounded number of flag bytes covering a span in milliseconds
    function automatic int flag_count(int span_ms);
        return (span_ms * BAUD_HZ + 4000) / 8000;
    endfunction

    // quarter-wave entry, sampled at the middle of each phase step
    function automatic logic [7:0] quarter_val(int i);
        real ang;
        real amp;
        ang = 3.141592653589793 * real'(2 * i + 1) / real'(PHASE_STEPS);
        amp = 127.0 * $sin(ang) + 0.5;
        return 8'(128 + $rtoi(amp));
    endfunction

    function automatic logic sends_raw(logic [7:0] b);
        return (b == FLAG_BYTE) || (b == ABORT_BYTE);
    endfunction

endpackage

// File: rtl/afskm_sine.sv
module afskm_sine
    import afskm_pkg::*;
(
    input  logic [PHASE_W-1:0]  phase,
    output logic [SAMPLE_W-1:0] level
);

    logic [7:0] qtab [QTR_LEN];

    for (genvar g = 0; g < QTR_LEN; g++) begin : g_qtab
        assign qtab[g] = quarter_val(g);
    end

    logic [QTR_W-1:0] qidx;
    logic [7:0]       qval;

    always_comb begin
        // second and fourth quarters run the table backwards
        qidx  = phase[PHASE_W-2] ? ~phase[QTR_W-1:0] : phase[QTR_W-1:0];
        qval  = qtab[qidx];
        // lower half-wave is the inverse of the upper one
        level = phase[PHASE_W-1] ? (8'd255 - qval) : qval;
    end

endmodule

// File: rtl/afskm_byte_hold.sv
module afskm_byte_hold
    import afskm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic       take,
    input  logic       drop_esc,
    output held_byte_t held,
    output logic       held_valid,
    output logic       esc_pending,
    output logic       accept
);

    held_byte_t held_q;
    logic       held_valid_q;
    logic       esc_q;

    assign in_ready    = !held_valid_q;
    assign accept      = in_valid && in_ready;
    assign held        = held_q;
    assign held_valid  = held_valid_q;
    assign esc_pending = esc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q       <= '0;
            held_valid_q <= 1'b0;
            esc_q        <= 1'b0;
        end else if (accept) begin
            if (!esc_q && in_data == ESC_BYTE) begin
                esc_q <= 1'b1;
            end else begin
                held_valid_q <= 1'b1;
                held_q       <= '{value: in_data, literal: esc_q};
                esc_q        <= 1'b0;
            end
        end else begin
            if (take)     held_valid_q <= 1'b0;
            if (drop_esc) esc_q        <= 1'b0;
        end
    end

endmodule

// File: rtl/afskm_nrzi.sv
module afskm_nrzi
    import afskm_pkg::*;
#(
    parameter int RUN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             step,
    input  logic             clr_run,
    input  logic             stuff_on,
    input  logic             data_bit,
    output tone_e            tone_next,
    output tone_e            tone_cur,
    output logic             consume,
    output logic [RUN_W-1:0] run_len
);

    localparam logic [RUN_W-1:0] RUN_LIMIT = RUN_W'(STUFF_RUN);
    localparam logic [RUN_W-1:0] RUN_TOP   = '1;

    logic [RUN_W-1:0] run_q, run_eff, run_d;
    tone_e            tone_q, tone_d, tone_flip;

    always_comb begin
        tone_flip = (tone_q == TONE_MARK) ? TONE_SPACE : TONE_MARK;
        run_eff   = clr_run ? '0 : run_q;
        run_d     = run_q;
        tone_d    = tone_q;
        consume   = 1'b0;
        if (step) begin
            if (stuff_on && run_eff >= RUN_LIMIT) begin
                run_d  = '0;
                tone_d = tone_flip;
            end else begin
                consume = 1'b1;
                if (data_bit) begin
                    run_d = (run_eff == RUN_TOP) ? run_eff : run_eff + 1'b1;
                end else begin
                    run_d  = '0;
                    tone_d = tone_flip;
                end
            end
        end
    end

    assign tone_next = tone_d;
    assign tone_cur  = tone_q;
    assign run_len   = run_q;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            run_q  <= '0;
            tone_q <= TONE_MARK;
        end else begin
            run_q  <= run_d;
            tone_q <= tone_d;
        end
    end

endmodule

// File: rtl/afsk_modulator.sv
module afsk_modulator
    import afskm_pkg::*;
#(
    parameter int SAMPLE_RATE = 9600,
    parameter int PREAMBLE_MS = 20,
    parameter int TRAILER_MS  = 14
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic       sample_req,
    output logic [7:0] sample_out,
    output logic       busy
);

    localparam int BIT_SAMPLES = SAMPLE_RATE / BAUD_HZ;
    localparam int CNT_W       = $clog2(BIT_SAMPLES + 1);
    localparam int PRE_FLAGS   = flag_count(PREAMBLE_MS);
    localparam int TRL_FLAGS   = flag_count(TRAILER_MS);
    localparam int FL_W        = $clog2(PRE_FLAGS + TRL_FLAGS + 2);
    localparam int BIT_W       = $clog2(BYTE_BITS + 1);
    localparam int RUN_W       = 4;

    localparam logic [PHASE_W-1:0] MARK_STEP  = PHASE_W'(tone_step(MARK_HZ, SAMPLE_RATE));
    localparam logic [PHASE_W-1:0] SPACE_STEP = PHASE_W'(tone_step(SPACE_HZ, SAMPLE_RATE));
    localparam logic [CNT_W-1:0]   CNT_LAST   = CNT_W'(BIT_SAMPLES - 1);
    localparam logic [FL_W-1:0]    PRE_LOAD   = FL_W'(PRE_FLAGS);
    localparam logic [FL_W-1:0]    TRL_LOAD   = FL_W'(TRL_FLAGS);
    localparam logic [BIT_W-1:0]   BIT_DONE   = BIT_W'(BYTE_BITS);

    // ---------------------------------------------------------------- state
    logic                busy_q;
    logic [7:0]          sample_q;
    logic [PHASE_W-1:0]  phase_q;
    logic [CNT_W-1:0]    scnt_q;
    logic [FL_W-1:0]     pre_q, trl_q;
    logic [BIT_W-1:0]    bit_q;
    logic [7:0]          cur_q;
    logic                stuff_en_q;

    // ------------------------------------------------------------ hold stage
    held_byte_t held;
    logic       held_valid, esc_pending, accept;
    logic       take, drop_esc;

    afskm_byte_hold u_hold (
        .clk         (clk),
        .rst         (rst),
        .in_data     (in_data),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .take        (take),
        .drop_esc    (drop_esc),
        .held        (held),
        .held_valid  (held_valid),
        .esc_pending (esc_pending),
        .accept      (accept)
    );

    // -------------------------------------------------------- sequencing
    logic start, active, at_bit, need_byte, queue_empty;
    logic stop_idle, stop_esc, halt, fetch, step;

    always_comb begin
        start       = !busy_q && (held_valid || esc_pending);
        active      = busy_q && sample_req;
        at_bit      = active && (scnt_q == '0);
        need_byte   = at_bit && (bit_q == BIT_DONE);
        queue_empty = !held_valid && !esc_pending;
        stop_idle   = need_byte && queue_empty && (trl_q == '0);
        stop_esc    = need_byte && !stop_idle && (pre_q == '0)
                      && !held_valid && esc_pending;
        halt        = stop_idle || stop_esc;
        fetch       = need_byte && !halt;
        step        = at_bit && !halt;
        drop_esc    = stop_esc;
    end

    // ---------------------------------------------------------- byte fetch
    logic [7:0]       byte_d;
    logic             lit_d;
    logic             stuff_en_d;
    logic [FL_W-1:0]  pre_d, trl_d;
    logic [BIT_W-1:0] bit_sel;
    logic             data_bit;

    always_comb begin
        byte_d = cur_q;
        lit_d  = 1'b0;
        take   = 1'b0;
        pre_d  = pre_q;
        trl_d  = trl_q;
        if (fetch) begin
            if (pre_q != '0) begin
                pre_d  = pre_q - 1'b1;
                byte_d = FLAG_BYTE;
            end else if (held_valid) begin
                byte_d = held.value;
                lit_d  = held.literal;
                take   = 1'b1;
            end else begin
                trl_d  = trl_q - 1'b1;
                byte_d = FLAG_BYTE;
            end
        end
        stuff_en_d = fetch ? (lit_d || !sends_raw(byte_d)) : stuff_en_q;
        bit_sel    = fetch ? '0 : bit_q;
        data_bit   = byte_d[bit_sel[2:0]];
    end

    // ------------------------------------------------------ NRZI and stuffing
    tone_e            tone_next, tone_cur;
    logic             consume;
    logic [RUN_W-1:0] run_len;

    afskm_nrzi #(.RUN_W(RUN_W)) u_nrzi (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .step      (step),
        .clr_run   (fetch && !stuff_en_q),
        .stuff_on  (stuff_en_d),
        .data_bit  (data_bit),
        .tone_next (tone_next),
        .tone_cur  (tone_cur),
        .consume   (consume),
        .run_len   (run_len)
    );

    // ------------------------------------------------------- phase and sine
    logic [PHASE_W-1:0] phase_d;
    logic [7:0]         level;

    assign phase_d = phase_q + ((tone_next == TONE_SPACE) ? SPACE_STEP : MARK_STEP);

    afskm_sine u_sine (
        .phase (phase_d),
        .level (level)
    );

    // ------------------------------------------------------------ registers
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q     <= 1'b0;
            sample_q   <= '0;
            phase_q    <= '0;
            scnt_q     <= '0;
            pre_q      <= '0;
            bit_q      <= BIT_DONE;
            cur_q      <= '0;
            stuff_en_q <= 1'b0;
        end else if (start) begin
            busy_q  <= 1'b1;
            phase_q <= '0;
            scnt_q  <= '0;
            pre_q   <= PRE_LOAD;
            bit_q   <= BIT_DONE;
        end else if (active) begin
            if (halt) begin
                busy_q   <= 1'b0;
                sample_q <= '0;
            end else begin
                phase_q    <= phase_d;
                sample_q   <= level;
                scnt_q     <= at_bit ? CNT_LAST : scnt_q - 1'b1;
                pre_q      <= pre_d;
                cur_q      <= byte_d;
                stuff_en_q <= stuff_en_d;
                bit_q      <= consume ? bit_sel + 1'b1 : bit_sel;
            end
        end
    end

    // trailer count restarts whenever a byte is taken in
    always_ff @(posedge clk) begin
        if (rst) begin
            trl_q <= '0;
        end else if (start || accept) begin
            trl_q <= TRL_LOAD;
        end else if (active && !halt) begin
            trl_q <= trl_d;
        end
    end

    assign sample_out = sample_q;
    assign busy       = busy_q;

endmodule

// File: rtl/afskm_checker.sv
module afskm_checker #(
    parameter int CW = 4,
    parameter int RW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          sample_req,
    input logic [7:0]    sample_out,
    input logic          in_valid,
    input logic          in_ready,
    input logic [7:0]    in_data,
    input logic          tone,
    input logic [CW-1:0] bit_timer,
    input logic          stuff_on,
    input logic [RW-1:0] run_len
);

    p_idle_silent_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> sample_out == 8'd0);

    p_out_moves_on_req_r4: assert property (@(posedge clk) disable iff (rst)
        !sample_req |=> $stable(sample_out));

    p_tone_fixed_mid_bit_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && sample_req && bit_timer != '0) |=> $stable(tone));

    p_run_bounded_r6: assert property (@(posedge clk) disable iff (rst)
        stuff_on |-> run_len <= RW'(5));

    p_busy_ends_on_req_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && !sample_req) |=> busy);

    p_accept_fills_r12: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_data != 8'h1B) |=> !in_ready);

endmodule

bind afsk_modulator afskm_checker #(.CW(CNT_W), .RW(RUN_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .sample_req (sample_req),
    .sample_out (sample_out),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .tone       (tone_cur == afskm_pkg::TONE_SPACE),
    .bit_timer  (scnt_q),
    .stuff_on   (stuff_en_q),
    .run_len    (run_len)
);

// File: tb/afsk_modulator_bench.sv
`timescale 1ns/1ps
module afsk_modulator_bench;

    typedef logic [7:0] byte_q_t [$];

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       sample_req = 1'b0;
    logic [7:0] sample_out;
    logic       busy;

    always #2.5 clk = ~clk;

    afsk_modulator u_afsk_modulator (
        .clk        (clk),
        .rst        (rst),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .sample_req (sample_req),
        .sample_out (sample_out),
        .busy       (busy)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected sine sample from the stated quarter-wave rule
    function automatic int bsin(input int ph);
        int i, v;
        i = ph % 256;
        if (i >= 128) i = 255 - i;
        v = 128 + $rtoi(127.0 * $sin(3.141592653589793 * real'(2 * i + 1) / 512.0) + 0.5);
        return (ph >= 256) ? 255 - v : v;
    endfunction

    // ------------------------------------------------ stimulus driver
    byte_q_t bq;
    logic    fire = 1'b0;

    task automatic cycle(input logic req);
        @(negedge clk);
        if (fire) void'(bq.pop_front());
        in_valid   = (bq.size() > 0);
        in_data    = (bq.size() > 0) ? bq[0] : 8'h00;
        fire       = in_valid && in_ready;
        sample_req = req;
    endtask

    // ------------------------------------------------ reference model
    byte_q_t    mq;
    bit         m_busy;
    int         m_pre, m_trl, m_cnt, m_bit, m_scnt, m_phase;
    bit         m_sen = 1'b0;
    bit         m_tone;
    logic [7:0] m_cur;

    task automatic model_start();
        m_busy = 1; m_pre = 3; m_trl = 2; m_cnt = 0;
        m_bit = 8; m_scnt = 0; m_phase = 0; m_tone = 0;
    endtask

    task automatic model_step(output int e);
        if (!m_busy) begin e = 0; return; end
        if (m_scnt == 0) begin
            if (m_bit == 8) begin
                if (mq.size() == 0 && m_trl == 0) begin m_busy = 0; e = 0; return; end
                if (!m_sen) m_cnt = 0;
                m_sen = 1;
                if (m_pre > 0) begin m_pre--; m_cur = 8'h7E; end
                else if (mq.size() == 0) begin m_trl--; m_cur = 8'h7E; end
                else m_cur = mq.pop_front();
                if (m_cur == 8'h1B) begin
                    if (mq.size() == 0) begin m_busy = 0; e = 0; return; end
                    m_cur = mq.pop_front();
                end else if (m_cur == 8'h7E || m_cur == 8'h7F) begin
                    m_sen = 0;
                end
                m_bit = 0;
            end
            if (m_sen && m_cnt >= 5) begin
                m_cnt = 0; m_tone = ~m_tone;
            end else begin
                if (m_cur[m_bit]) m_cnt++;
                else begin m_cnt = 0; m_tone = ~m_tone; end
                m_bit++;
            end
            m_scnt = 8;
        end
        m_phase = (m_phase + (m_tone ? 117 : 64)) % 512;
        m_scnt--;
        e = bsin(m_phase);
    endtask

    // ------------------------------------------------ scenarios
    int got [$];

    task automatic run_frame(input byte_q_t bytes, input string tag, input int exp_len);
        int e;
        int guard;
        got.delete();
        bq = bytes;
        mq = bytes;
        fire = 1'b0;
        model_start();
        cycle(0);
        cycle(0);
        if (bytes[0] != 8'h1B) chk("R12 ready low after accept", int'(in_ready), 0);
        chk("R12 busy not yet", int'(busy), 0);
        cycle(0);
        chk("R12 busy rises", int'(busy), 1);
        guard = 0;
        while (m_busy && guard < 3000) begin
            cycle(1);
            cycle(0);
            model_step(e);
            chk(tag, int'(sample_out), e);
            chk(tag, int'(busy), int'(m_busy));
            if (m_busy) got.push_back(int'(sample_out));
            cycle(0);
            cycle(0);
            guard++;
        end
        chk({tag, " R4 length"}, got.size(), exp_len);
        chk("R10 idle after end", int'(busy), 0);
        chk("R10 output zero", int'(sample_out), 0);
    endtask

    task automatic t_reset();
        chk("R1 reset busy", int'(busy), 0);
        chk("R1 reset out", int'(sample_out), 0);
        chk("R1 reset ready", int'(in_ready), 1);
    endtask

    task automatic t_idle_req();
        for (int k = 0; k < 3; k++) begin
            cycle(1);
            cycle(0);
            chk("R1 idle request", int'(sample_out), 0);
            chk("R1 idle busy", int'(busy), 0);
        end
    endtask

    task automatic t_plain_zero();
        run_frame('{8'h00}, "R9 preamble frame", 384);
        // first flag bit is 0: switch to space at phase 0
        chk("R3 first sample", got[0], bsin(117));
        chk("R2 second sample", got[1], bsin(234));
        // bit 1 of the flag is 1: tone stays on space
        chk("R5 one keeps tone", got[8], bsin((9 * 117) % 512));
        // bit 7 of the flag is 0: back to mark
        chk("R5 zero changes tone", got[56], bsin((56 * 117 + 64) % 512));
    endtask

    task automatic t_ones_run();
        run_frame('{8'hFF, 8'hFF}, "R6 stuffing", 472);
    endtask

    task automatic t_raw_abort();
        run_frame('{8'h7F}, "R7 unstuffed abort", 384);
    endtask

    task automatic t_escaped_flag();
        run_frame('{8'h1B, 8'h7E}, "R8 escaped flag", 392);
    endtask

    task automatic t_dangling_esc();
        run_frame('{8'h41, 8'h1B}, "R11 dangling escape", 256);
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) cycle(0);
        @(negedge clk) rst = 1'b0;
        cycle(0);
        t_reset();
        t_idle_req();
        t_plain_zero();
        t_ones_run();
        t_raw_abort();
        t_escaped_flag();
        t_dangling_esc();
        t_idle_req();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule